// File: doc/BRIEF.md
# Half-to-Single Precision Widening Converter

This block takes a 32-bit word that holds two packed half-precision values. It picks one of them and widens it to an IEEE single-precision value, which appears on a registered output one clock after the inputs. Every half value can be represented exactly in single precision, so the block has no rounding stage.

Half subnormals come out as single normals. The block counts the leading zeros of the fraction to find the normalising shift, so the whole conversion takes one cycle.

Two mode inputs control the conversion:
- The alternative-half mode treats the top half exponent as an ordinary magnitude, with no infinities or NaNs.
- The default-NaN mode replaces every NaN result with the canonical positive quiet NaN.

The only flag the block produces is an invalid-operation flag. It is raised when a signalling NaN is quietened.

Top module: `h2s_widen`

## Requirements
- R1: When `sel_upper` is 1, the half operand is bits 31..16 of `src_word`. When it is 0, the operand is bits 15..0. The other 16 bits have no effect on the outputs.
- R2: A half operand with an exponent field from 1 to 30 (bits 14..10) converts to single exponent (half exponent + 112) in bits 30..23 and single fraction (half fraction << 13) in bits 22..0. The sign bit 15 is copied to bit 31.
- R3: A half zero (exponent 0, fraction 0) gives a single zero (bits 30..0 all 0) with the same sign.
- R4: A nonzero half subnormal whose highest set fraction bit is at position p (0..9) gives single exponent 103+p. The single fraction is the half fraction shifted left by 23-p, with the leading one removed. The sign is kept and the invalid flag is 0.
- R5: With `alt_half`=0, a half operand with exponent 31 and fraction 0 gives a single infinity (exponent 0xFF, fraction 0) with the same sign and invalid 0.
- R6: With `alt_half`=0 and `dflt_nan`=0, a half NaN (exponent 31, nonzero fraction) gives single exponent 0xFF and fraction (half fraction << 13) with bit 22 forced to 1, and the sign is kept. `invalid_o` is 1 exactly when half fraction bit 9 was 0 (a signalling NaN).
- R7: With `alt_half`=0 and `dflt_nan`=1, every half NaN gives 0x7FC00000. `invalid_o` is still 1 exactly for signalling NaNs.
- R8: With `alt_half`=1, exponent 31 converts as a normal number (single exponent 143), and `invalid_o` is 0 for every operand.
- R9: The outputs are registered. A conversion of the inputs present at a rising edge appears after that edge and holds until the next edge. A synchronous active-high `rst` clears `result_o` and `invalid_o` to 0.
- R10: `dflt_nan` has no effect on results that are not NaNs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_word | input | 32 | Word holding two packed half values |
| sel_upper | input | 1 | 1 selects bits 31..16, 0 selects bits 15..0 |
| alt_half | input | 1 | Exponent 31 is an ordinary magnitude |
| dflt_nan | input | 1 | NaN results become the canonical quiet NaN |
| result_o | output | 32 | Registered single-precision result |
| invalid_o | output | 1 | Registered invalid-operation flag |

## Verification
All 65536 half encodings are converted with both mode inputs off. The selected half alternates between the upper and lower positions, and the unused half holds a value derived from the operand. This separates the normal, zero, subnormal, infinity, quiet-NaN and signalling-NaN paths, and exposes any leak from the unselected half.

Every encoding with exponent 0 or 31 is then repeated under the other three mode combinations. This tells the alternative-half path apart from the NaN and infinity path, and shows that default-NaN changes NaN results only.

A strided sweep of normal operands with mixed mode settings confirms that the modes leave ordinary numbers untouched. A dedicated check shows that the output holds between clock edges.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  localparam int H_EXP    = 5;
  localparam int H_FRAC   = 10;
  localparam int S_EXP    = 8;
  localparam int S_FRAC   = 23;
  localparam int H_W      = 1 + H_EXP + H_FRAC;
  localparam int S_W      = 1 + S_EXP + S_FRAC;
  localparam int WORD_W   = 2 * H_W;
  localparam int FRAC_PAD = S_FRAC - H_FRAC;
  localparam int H_BIAS   = (1 << (H_EXP - 1)) - 1;
  localparam int S_BIAS   = (1 << (S_EXP - 1)) - 1;
  localparam int BIAS_GAP = S_BIAS - H_BIAS;
  localparam int LZ_W     = $clog2(H_FRAC + 1);

  typedef struct packed {
    logic              sgn;
    logic [H_EXP-1:0]  ex;
    logic [H_FRAC-1:0] fr;
  } half_t;

  typedef struct packed {
    logic              sgn;
    logic [S_EXP-1:0]  ex;
    logic [S_FRAC-1:0] fr;
  } single_t;
endpackage

// File: rtl/h2s_pick.sv
module h2s_pick
  import h2s_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              sel_hi,
  output half_t             half_o
);
  always_comb begin
    if (sel_hi) half_o = half_t'(word_i[WORD_W-1:H_W]);
    else        half_o = half_t'(word_i[H_W-1:0]);
  end
endmodule

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
  parameter int W  = 10,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end

  logic [W-1:0] lead_chk;
  assign lead_chk = vec_i << cnt_o;

  // After shifting by the count, the leading one must sit at the top (R4)
  always_comb begin
    if (vec_i != '0)
      assert_lzc_lead_R4: assert (lead_chk[W-1]);
  end
endmodule

// File: rtl/h2s_expand.sv
module h2s_expand
  import h2s_pkg::*;
(
  input  half_t   half_i,
  input  logic    alt_i,
  input  logic    dn_i,
  output single_t sgl_o,
  output logic    inv_o
);
  logic             exp_zero, exp_top, frac_nz;
  logic [LZ_W-1:0]  lz;
  logic [H_FRAC-1:0] sub_fr;

  assign exp_zero = (half_i.ex == '0);
  assign exp_top  = (&half_i.ex);
  assign frac_nz  = (|half_i.fr);

  h2s_lzc #(.W(H_FRAC), .CW(LZ_W)) u_lzc (
    .vec_i (half_i.fr),
    .cnt_o (lz)
  );

  // Shift past the leading one so the hidden bit falls off the top
  assign sub_fr = half_i.fr << (lz + 1);

  always_comb begin
    sgl_o.sgn = half_i.sgn;
    sgl_o.ex  = S_EXP'(half_i.ex) + S_EXP'(BIAS_GAP);
    sgl_o.fr  = {half_i.fr, {FRAC_PAD{1'b0}}};
    inv_o     = 1'b0;
    if (exp_zero) begin
      if (!frac_nz) begin
        sgl_o.ex = '0;
      end else begin
        sgl_o.ex = S_EXP'(BIAS_GAP) - S_EXP'(lz);
        sgl_o.fr = {sub_fr, {FRAC_PAD{1'b0}}};
      end
    end else if (exp_top && !alt_i) begin
      sgl_o.ex = '1;
      if (frac_nz) begin
        if (!half_i.fr[H_FRAC-1]) inv_o = 1'b1;
        sgl_o.fr[S_FRAC-1] = 1'b1;
        if (dn_i) begin
          sgl_o.fr[S_FRAC-2:0] = '0;
          sgl_o.sgn = 1'b0;
        end
      end
    end
  end

  // The flag only accompanies a quiet NaN result built outside alt mode (R6)
  always_comb begin
    if (inv_o)
      assert_inv_nan_R6: assert (sgl_o.ex == '1 && !alt_i && sgl_o.fr[S_FRAC-1]);
  end

  // Subnormal results stay inside the normal exponent window (R4)
  always_comb begin
    if (exp_zero && frac_nz)
      assert_sub_range_R4: assert (sgl_o.ex <= S_EXP'(BIAS_GAP) &&
                                   sgl_o.ex >= S_EXP'(BIAS_GAP - H_FRAC + 1));
  end
endmodule

// File: rtl/h2s_widen.sv
module h2s_widen
  import h2s_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] src_word,
  input  logic        sel_upper,
  input  logic        alt_half,
  input  logic        dflt_nan,
  output logic [31:0] result_o,
  output logic        invalid_o
);
  half_t   half_sel;
  single_t sgl_c;
  logic    inv_c;

  h2s_pick u_pick (
    .word_i (src_word),
    .sel_hi (sel_upper),
    .half_o (half_sel)
  );

  h2s_expand u_expand (
    .half_i (half_sel),
    .alt_i  (alt_half),
    .dn_i   (dflt_nan),
    .sgl_o  (sgl_c),
    .inv_o  (inv_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      invalid_o <= 1'b0;
    end else begin
      result_o  <= sgl_c;
      invalid_o <= inv_c;
    end
  end

  assert_inf_noflag_R5: assert property (@(posedge clk) disable iff (rst)
    (result_o[30:0] == 31'h7F80_0000) |-> !invalid_o);

  assert_alt_noflag_R8: assert property (@(posedge clk) disable iff (rst)
    $past(alt_half) |-> !invalid_o);

  assert_dn_canon_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(dflt_nan) && result_o[30:23] == 8'hFF && result_o[22:0] != '0)
    |-> (result_o == 32'h7FC0_0000));
endmodule

// File: tb/h2s_widen_bench.sv
module h2s_widen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_word = '0;
  logic        sel_upper = 1'b0;
  logic        alt_half = 1'b0;
  logic        dflt_nan = 1'b0;
  logic [31:0] result_o;
  logic        invalid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  h2s_widen u_h2s_widen (
    .clk       (clk),
    .rst       (rst),
    .src_word  (src_word),
    .sel_upper (sel_upper),
    .alt_half  (alt_half),
    .dflt_nan  (dflt_nan),
    .result_o  (result_o),
    .invalid_o (invalid_o)
  );

  function automatic logic [32:0] model(input logic [15:0] hv, input logic alt, input logic dn);
    logic s;
    int e, f, p, frac;
    logic [31:0] r;
    logic inv;
    s = hv[15]; e = int'(hv[14:10]); f = int'(hv[9:0]);
    inv = 1'b0;
    if (e == 0 && f == 0) begin
      r = {s, 31'b0};
    end else if (e == 0) begin
      p = 0;
      for (int i = 0; i < 10; i++) if (hv[i]) p = i;
      frac = (f << (23 - p)) & 32'h007F_FFFF;
      r = {s, 8'(103 + p), frac[22:0]};
    end else if (e == 31 && !alt) begin
      if (f == 0) r = {s, 8'hFF, 23'b0};
      else begin
        inv = !hv[9];
        if (dn) r = 32'h7FC0_0000;
        else    r = {s, 8'hFF, 1'b1, hv[8:0], 13'b0};
      end
    end else begin
      r = {s, 8'(e + 112), hv[9:0], 13'b0};
    end
    return {inv, r};
  endfunction

  function automatic string tag_of(input logic [15:0] hv, input logic alt, input logic dn);
    if (hv[14:10] == 5'd0) return (hv[9:0] == 0) ? "R3" : "R4";
    if (hv[14:10] == 5'd31 && !alt) begin
      if (hv[9:0] == 0) return "R5";
      return dn ? "R7" : "R6";
    end
    if (hv[14:10] == 5'd31) return "R8";
    return dn ? "R10" : "R2";
  endfunction

  task automatic check(input string tag, input logic [31:0] got_r, input logic got_i,
                       input logic [31:0] exp_r, input logic exp_i);
    n_chk++;
    if (got_r !== exp_r || got_i !== exp_i) begin
      n_bad++;
      $display("FAIL %s: got result=%h inv=%b expected result=%h inv=%b",
               tag, got_r, got_i, exp_r, exp_i);
    end
  endtask

  // Called at a falling edge; result is sampled at the following falling edge
  task automatic run_vec(input logic [15:0] hv, input logic sel, input logic alt, input logic dn);
    logic [15:0] junk;
    logic [32:0] e;
    junk = ~hv ^ 16'h5A3C;
    src_word  = sel ? {hv, junk} : {junk, hv};
    sel_upper = sel;
    alt_half  = alt;
    dflt_nan  = dn;
    e = model(hv, alt, dn);
    @(negedge clk);
    check({tag_of(hv, alt, dn), sel ? " R1 upper" : " R1 lower"},
          result_o, invalid_o, e[31:0], e[32]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(10 * 300000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [32:0] e;
    src_word = 32'hFFFF_FFFF; sel_upper = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset", result_o, invalid_o, 32'h0, 1'b0);
    rst = 1'b0;

    // Pass 1: every encoding, modes off, both positions
    for (int i = 0; i < 65536; i++) run_vec(16'(i), i[0], 1'b0, 1'b0);

    // Pass 2: exponent 0 and 31 under the other mode combinations
    for (int m = 1; m < 4; m++)
      for (int k = 0; k < 4096; k++) begin
        logic [15:0] hv;
        hv = {k[11], k[10] ? 5'd31 : 5'd0, k[9:0]};
        run_vec(hv, k[0] ^ m[0], m[1], m[0]);
      end

    // Pass 3: strided normals with mixed modes
    for (int i = 0; i < 4096; i++) run_vec(16'(i * 16 + 3), i[2], i[0], i[1]);

    // R9: output holds between edges, then updates after the edge
    run_vec(16'h3C00, 1'b0, 1'b0, 1'b0);
    src_word = {16'h0, 16'hC000};
    #2;
    check("R9 hold", result_o, invalid_o, 32'h3F80_0000, 1'b0);
    e = model(16'hC000, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 update", result_o, invalid_o, e[31:0], e[32]);

    // R9: synchronous reset clears a live result
    run_vec(16'h7C01, 1'b0, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset live", result_o, invalid_o, 32'h0, 1'b0);
    rst = 1'b0;
    finish_run();
  end
endmodule